// File: doc/BRIEF.md
# Serial Bit Destuffer with Stuff-Error Detection

This block sits on the receive path of a serial bus controller and removes the stuff bits that a transmitter inserted into the bit stream. One received bit is handled per destuff trigger pulse. In run-length mode, a stuff bit is expected after a run of equal bits. In fixed-interval mode, a stuff bit is expected after every group of data bits, whatever their values. When the mode changes from run-length to fixed-interval, one extra stuff bit is expected.

Each expected stuff bit is removed and flagged, so that the receive logic skips that slot. Its polarity is also checked. When a stuff bit has the same value as the bit before it, and error checking is enabled, the block reports a stuff error. The current value of the destuff counter is visible on an output.

Top module: `bit_destuffer`

## Requirements
- R1: A synchronous active-high `rst` sets `data_out` to 1 and sets `destuffed`, `stuff_err` and `count` to 0. The reference bit for the first polarity comparison is 1, and the block starts in run-length mode.
- R2: In run-length mode (`fixed_mode`=0), once `count` equals the effective rule length, the next triggered bit is a stuff bit. `destuffed` goes to 1 for that slot. A stuff bit of correct polarity starts a new run, and `count` becomes 1.
- R3: On the first trigger after `fixed_mode` falls, the bit is treated as data and `count` becomes 1.
- R4: A stuff bit equal to the previous received bit, with `err_en`=1, sets `stuff_err` to 1 for that slot only. It also clears `count` to 0.
- R5: With `err_en`=0, a stuff bit of wrong polarity is still removed and `stuff_err` stays 0.
- R6: In fixed-interval mode, a stuff bit is expected once `count` data bits reach the effective rule length, regardless of the bit values. After it, `count` is 0.
- R7: The first trigger with `fixed_mode`=1 after run-length mode is a forced stuff bit. It is removed, its polarity is checked against the previous bit, and `count` becomes 0 afterwards.
- R8: On a data slot, `data_out` takes the received bit and `destuffed` is 0. On a stuff slot, `data_out` keeps its last value.
- R9: While `enable`=0, `count` is 0 and `destuffed` and `stuff_err` are 0. The mode is tracked without raising a forced stuff bit.
- R10: `count` shows the number of equal bits in the current run (run-length mode), or the number of data bits since the last stuff bit (fixed-interval mode).
- R11: A rule length below 3 acts as 3. Lengths 3 to 7 are used as given.
- R12: On enabled cycles without a trigger, all outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Destuffing enable |
| trig | input | 1 | One-cycle pulse: process `rx_bit` |
| rx_bit | input | 1 | Received bus bit |
| fixed_mode | input | 1 | 1 selects fixed-interval mode |
| rule_len | input | LEN_W (3) | Stuff rule length |
| err_en | input | 1 | Enables stuff-error reporting |
| data_out | output | 1 | Last destuffed data bit |
| destuffed | output | 1 | Current slot held a stuff bit |
| stuff_err | output | 1 | Current slot held a wrong-polarity stuff bit |
| count | output | CNT_W (3) | Destuff counter value |

## Verification
The assertions assume that `trig` is a single-cycle pulse, and that `rule_len`, `fixed_mode` and `err_en` do not change in the cycle a trigger is sampled. They also assume that the stuff-error flag is only ever judged on slots that were triggered. The stimulus meets these assumptions in three ways:
- It changes settings only between trigger pulses.
- It spaces triggers three clocks apart.
- It draws received bits with a strong bias toward repeats, so that runs, stuff slots and wrong-polarity stuff bits all occur.

It also covers rule lengths below 3 and mode changes in both directions.

// File: rtl/bds_pkg.sv
package bds_pkg;
  localparam int MIN_RULE = 3;

  typedef enum logic [2:0] {
    SLOT_RUN_DATA,
    SLOT_RUN_STUFF,
    SLOT_FIXED_DATA,
    SLOT_FIXED_STUFF,
    SLOT_MODE_STUFF,
    SLOT_RESTART
  } slot_e;
endpackage

// File: rtl/bds_classify.sv
module bds_classify
  import bds_pkg::*;
#(
  parameter int CNT_W = 3,
  parameter int LEN_W = 3
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [LEN_W-1:0] rule_len,
  input  logic             fixed_mode,
  input  logic             fixed_q,
  input  logic             rx_bit,
  input  logic             prev_bit,
  input  logic             err_en,
  output slot_e            kind,
  output logic             is_stuff,
  output logic             raise_err
);
  localparam logic [CNT_W-1:0] MIN_L = CNT_W'(MIN_RULE);

  logic [CNT_W-1:0] len_ext;
  logic [CNT_W-1:0] eff_len;
  logic             at_limit;

  always_comb begin
    len_ext  = CNT_W'(rule_len);
    eff_len  = (len_ext < MIN_L) ? MIN_L : len_ext;
    at_limit = (cnt >= eff_len);
  end

  always_comb begin
    if (fixed_mode && !fixed_q)      kind = SLOT_MODE_STUFF;
    else if (fixed_mode)             kind = at_limit ? SLOT_FIXED_STUFF : SLOT_FIXED_DATA;
    else if (fixed_q)                kind = SLOT_RESTART;
    else                             kind = at_limit ? SLOT_RUN_STUFF : SLOT_RUN_DATA;
  end

  always_comb begin
    is_stuff  = (kind == SLOT_RUN_STUFF) || (kind == SLOT_FIXED_STUFF) ||
                (kind == SLOT_MODE_STUFF);
    raise_err = is_stuff && err_en && (rx_bit == prev_bit);
  end
endmodule

// File: rtl/bds_counter.sv
module bds_counter
  import bds_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             trig,
  input  logic             rx_bit,
  input  logic             fixed_mode,
  input  slot_e            kind,
  input  logic             raise_err,
  output logic [CNT_W-1:0] cnt_q,
  output logic             prev_q,
  output logic             fixed_q
);
  logic [CNT_W-1:0] cnt_nx;

  always_comb begin
    unique case (kind)
      SLOT_MODE_STUFF,
      SLOT_FIXED_STUFF: cnt_nx = '0;
      SLOT_FIXED_DATA:  cnt_nx = cnt_q + 1'b1;
      SLOT_RESTART:     cnt_nx = CNT_W'(1);
      SLOT_RUN_STUFF:   cnt_nx = CNT_W'(1);
      SLOT_RUN_DATA:    cnt_nx = ((cnt_q != '0) && (rx_bit == prev_q)) ?
                                 cnt_q + 1'b1 : CNT_W'(1);
      default:          cnt_nx = '0;
    endcase
    if (raise_err) cnt_nx = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      prev_q  <= 1'b1;
      fixed_q <= 1'b0;
    end else if (!enable) begin
      cnt_q   <= '0;
      fixed_q <= fixed_mode;
    end else if (trig) begin
      cnt_q   <= cnt_nx;
      prev_q  <= rx_bit;
      fixed_q <= fixed_mode;
    end
  end
endmodule

// File: rtl/bds_outreg.sv
module bds_outreg (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic trig,
  input  logic rx_bit,
  input  logic is_stuff,
  input  logic raise_err,
  output logic data_q,
  output logic dst_q,
  output logic err_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= 1'b1;
      dst_q  <= 1'b0;
      err_q  <= 1'b0;
    end else if (!enable) begin
      dst_q  <= 1'b0;
      err_q  <= 1'b0;
    end else if (trig) begin
      dst_q  <= is_stuff;
      err_q  <= raise_err;
      if (!is_stuff) data_q <= rx_bit;
    end
  end
endmodule

// File: rtl/bit_destuffer.sv
module bit_destuffer
  import bds_pkg::*;
#(
  parameter int CNT_W = 3,
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             trig,
  input  logic             rx_bit,
  input  logic             fixed_mode,
  input  logic [LEN_W-1:0] rule_len,
  input  logic             err_en,
  output logic             data_out,
  output logic             destuffed,
  output logic             stuff_err,
  output logic [CNT_W-1:0] count
);
  slot_e            kind;
  logic             is_stuff;
  logic             raise_err;
  logic [CNT_W-1:0] cnt_q;
  logic             prev_q;
  logic             fixed_q;

  bds_classify #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_cls (
    .cnt(cnt_q), .rule_len(rule_len), .fixed_mode(fixed_mode), .fixed_q(fixed_q),
    .rx_bit(rx_bit), .prev_bit(prev_q), .err_en(err_en),
    .kind(kind), .is_stuff(is_stuff), .raise_err(raise_err)
  );

  bds_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .enable(enable), .trig(trig), .rx_bit(rx_bit),
    .fixed_mode(fixed_mode), .kind(kind), .raise_err(raise_err),
    .cnt_q(cnt_q), .prev_q(prev_q), .fixed_q(fixed_q)
  );

  bds_outreg u_out (
    .clk(clk), .rst(rst), .enable(enable), .trig(trig), .rx_bit(rx_bit),
    .is_stuff(is_stuff), .raise_err(raise_err),
    .data_q(data_out), .dst_q(destuffed), .err_q(stuff_err)
  );

  assign count = cnt_q;
endmodule

// File: rtl/bds_checker.sv
module bds_checker #(
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             enable,
  input logic             trig,
  input logic             err_en,
  input logic             data_out,
  input logic             destuffed,
  input logic             stuff_err,
  input logic [CNT_W-1:0] count
);
  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!destuffed && !stuff_err && count == '0)); // R9

  AST_ERR_ON_STUFF_ONLY: assert property (@(posedge clk) disable iff (rst)
    stuff_err |-> destuffed); // R4

  AST_ERR_CLEARS_COUNT: assert property (@(posedge clk) disable iff (rst)
    (enable && trig) |=> (!stuff_err || count == '0)); // R4

  AST_NO_ERR_UNCHECKED: assert property (@(posedge clk) disable iff (rst)
    (enable && trig && !err_en) |=> !stuff_err); // R5

  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (rst)
    (enable && trig) |=> (!destuffed || $stable(data_out))); // R8

  AST_QUIET_BETWEEN: assert property (@(posedge clk) disable iff (rst)
    (enable && !trig) |=> ($stable(destuffed) && $stable(stuff_err) &&
                           $stable(data_out) && $stable(count))); // R12
endmodule

bind bit_destuffer bds_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .enable(enable), .trig(trig), .err_en(err_en),
  .data_out(data_out), .destuffed(destuffed), .stuff_err(stuff_err), .count(count)
);

// File: tb/sim_bit_destuffer.sv
module sim_bit_destuffer;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enable = 1'b0;
  logic       trig = 1'b0;
  logic       rx_bit = 1'b1;
  logic       fixed_mode = 1'b0;
  logic [2:0] rule_len = 3'd4;
  logic       err_en = 1'b1;
  logic       data_out, destuffed, stuff_err;
  logic [2:0] count;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference model state
  int    m_cnt = 0;
  bit    m_prev = 1, m_fixq = 0, m_dout = 1, m_dst = 0, m_err = 0;
  string m_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  bit_destuffer u0 (
    .clk(clk), .rst(rst), .enable(enable), .trig(trig), .rx_bit(rx_bit),
    .fixed_mode(fixed_mode), .rule_len(rule_len), .err_en(err_en),
    .data_out(data_out), .destuffed(destuffed), .stuff_err(stuff_err), .count(count)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_prev = 1; m_fixq = 0; m_dout = 1; m_dst = 0; m_err = 0;
      m_tag = "R1";
    end else if (!enable) begin
      m_cnt = 0; m_dst = 0; m_err = 0; m_fixq = fixed_mode;
      m_tag = "R9";
    end else if (trig) begin
      int  lim;
      bit  stuff;
      bit  bad;
      lim   = (rule_len < 3) ? 3 : int'(rule_len);
      stuff = 0;
      bad   = (rx_bit == m_prev);
      if (fixed_mode && !m_fixq) begin
        stuff = 1; m_cnt = 0; m_tag = "R7";
      end else if (fixed_mode) begin
        if (m_cnt >= lim) begin stuff = 1; m_cnt = 0; end
        else m_cnt = m_cnt + 1;
        m_tag = "R6";
      end else if (m_fixq) begin
        m_cnt = 1; m_tag = "R3";
      end else if (m_cnt >= lim) begin
        stuff = 1; m_cnt = 1; m_tag = "R2";
      end else begin
        m_cnt = (m_cnt != 0 && rx_bit == m_prev) ? m_cnt + 1 : 1;
        m_tag = "R8";
      end
      if (stuff) begin
        m_dst = 1;
        m_err = bad && err_en;
        if (m_err) begin m_cnt = 0; m_tag = "R4"; end
        else if (bad) m_tag = "R5";
      end else begin
        m_dst = 0; m_err = 0; m_dout = rx_bit;
      end
      m_prev = rx_bit;
      m_fixq = fixed_mode;
      if (rule_len < 3) m_tag = "R11";
    end else begin
      m_tag = "R12";
    end
  end

  task automatic cmp();
    checks++;
    if (data_out !== m_dout || destuffed !== m_dst || stuff_err !== m_err) begin
      failures++;
      $display("FAIL %s: dout/dst/err actual=%b%b%b expected=%b%b%b at %0t",
               m_tag, data_out, destuffed, stuff_err, m_dout, m_dst, m_err, $time);
    end
    checks++;
    if (int'(count) != m_cnt) begin
      failures++;
      $display("FAIL R10 (%s): count actual=%0d expected=%0d at %0t",
               m_tag, count, m_cnt, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (!done) cmp();
  endtask

  task automatic send(int n, int rep_pct);
    for (int i = 0; i < n; i++) begin
      rx_bit = (($urandom % 100) < rep_pct) ? rx_bit : ~rx_bit;
      trig = 1'b1;
      step();
      trig = 1'b0;
      step();
      step();
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst = 1'b0;
    step();                                   // R1 reset state
    enable = 1'b1; step();
    rule_len = 3'd4; err_en = 1'b1;           // R2 R4 run-length, checked
    send(80, 80);
    rule_len = 3'd3; err_en = 1'b0;           // R5 unchecked polarity
    send(60, 85);
    err_en = 1'b1; rule_len = 3'd5;
    fixed_mode = 1'b1;                        // R7 forced bit, R6 fixed
    send(60, 50);
    fixed_mode = 1'b0;                        // R3 restart
    send(40, 80);
    enable = 1'b0;                            // R9
    repeat (6) step();
    fixed_mode = 1'b1;
    step();
    enable = 1'b1;
    send(30, 50);
    fixed_mode = 1'b0;
    rule_len = 3'd1;                          // R11
    send(50, 85);
    rule_len = 3'd7;
    send(60, 90);
    fixed_mode = 1'b1; err_en = 1'b0;
    send(40, 50);
    rst = 1'b1; step(); rst = 1'b0; step();   // R1 again
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule